// File: doc/BRIEF.md
# Sideband Request Header Formatter

This block turns one request description into the byte sequence that opens a transaction on a display link's auxiliary sideband channel. It serves three request kinds: native register writes, native register reads, and single-step I2C transfers tunnelled over the sideband. The caller places the kind, the address, the byte count, the I2C step and up to sixteen payload bytes on the inputs. It then pulses `start_i`. The block presents the request one byte per transfer on a valid/ready stream and flags the final byte.

The header is four bytes. The first two bytes carry the address, low byte first. The third byte carries a command code in its upper nibble. The fourth byte packs a length nibble above a count-minus-one field. Native writes append their payload after the header. An I2C write step appends one data byte. For I2C, the continuation flag and the read/write choice come from the step and from the address LSB. Requests whose byte count cannot be encoded are refused: an error pulse is raised and no byte is sent. The inputs must stay unchanged from the accepted start pulse until the last byte has been transferred.

Top module: `aux_req_fmt`

## Requirements
- R1: After reset, `tx_valid_o`, `tx_last_o` and `err_o` are low.
- R2: For native requests, byte 0 is `addr_i[7:0]` and byte 1 is `addr_i[15:8]`.
- R3: A native write (`kind_i`=2'b00) of N bytes (1..16) sends N+4 bytes. Byte 2 is 0x80. Byte 3 carries the low four bits of 4+N in its upper nibble and N-1 in its lower nibble. Byte 4+k is `wdata_i[8k+7:8k]`.
- R4: A native read (`kind_i`=2'b01) of N bytes (1..16) sends exactly 4 bytes. Byte 2 is 0x90 and byte 3 is 0x40 | (N-1).
- R5: A request with `kind_i`=2'b11, or a native request with N=0 or N>16, sends no byte. Instead, `err_o` is high for exactly the one cycle after the start pulse.
- R6: For I2C (`kind_i`=2'b10), byte 2 has a zero lower nibble. Its upper nibble is 0x4 for every step except stop (`mode_i`: 00 start, 01 write, 10 read, 11 stop), ORed with 0x1 when `addr_i[0]` is 1.
- R7: For I2C, byte 0 is `addr_i[8:1]` and byte 1 is `{1'b0, addr_i[15:9]}`.
- R8: For I2C, byte 3 has a zero lower nibble. Its upper nibble is 3 for start and stop, 4 for read and 5 for write. A write step sends 5 bytes, the last being `wdata_i[7:0]`; all other steps send 4 bytes.
- R9: `tx_last_o` is high exactly on the final byte of a request and never without `tx_valid_o`.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` and `tx_data_o` hold.
- R11: A start pulse while a request is in flight is ignored. After the last byte transfers, `tx_valid_o` is low.
- R12: `tx_valid_o` rises in the cycle after an accepted start. With `tx_ready_i` held high, one byte transfers per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a request, sampled when idle |
| kind_i | input | 2 | 00 native write, 01 native read, 10 I2C, 11 reserved |
| mode_i | input | 2 | I2C step: 00 start, 01 write, 10 read, 11 stop |
| addr_i | input | 16 | Register address, or I2C slave address in 8-bit form |
| len_i | input | 5 | Native byte count N |
| wdata_i | input | 128 | Payload bytes, byte k at bits 8k+7:8k |
| tx_data_o | output | 8 | Stream byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_ready_i | input | 1 | Stream sink ready |
| tx_last_o | output | 1 | Final byte of the request |
| err_o | output | 1 | One-cycle pulse on a refused request |

## Verification
The assertions check on every cycle that the stream holds still under backpressure and that the last flag appears only with valid. They also check that the byte index stays inside the request length, that the error pulse lasts one cycle, and that a start during a request does not end it. The byte values themselves can only be shown by the bench's scenarios. Those scenarios sweep native writes and reads over every count from 1 to 16, every I2C step with both address LSB values, and each refused count and kind. They compare every streamed byte and last flag against values computed arithmetically from the requirements.

// File: rtl/aux_req_pkg.sv
package aux_req_pkg;
  typedef enum logic [1:0] {
    KIND_NWR = 2'b00,
    KIND_NRD = 2'b01,
    KIND_I2C = 2'b10,
    KIND_RSV = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    STEP_START = 2'b00,
    STEP_WRITE = 2'b01,
    STEP_READ  = 2'b10,
    STEP_STOP  = 2'b11
  } step_e;

  localparam logic [3:0] CMD_NWR   = 4'h8;
  localparam logic [3:0] CMD_NRD   = 4'h9;
  localparam logic [3:0] CMD_MOT   = 4'h4;
  localparam int         HDR_BYTES = 4;
endpackage

// File: rtl/aux_req_hdr.sv
module aux_req_hdr
  import aux_req_pkg::*;
#(
  parameter int AW          = 16,
  parameter int MAX_PAYLOAD = 16,
  parameter int LW          = $clog2(MAX_PAYLOAD + 1),
  parameter int CW          = $clog2(MAX_PAYLOAD + HDR_BYTES + 1)
) (
  input  logic [1:0]               kind_i,
  input  logic [1:0]               mode_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [LW-1:0]            len_i,
  input  logic [8*MAX_PAYLOAD-1:0] wdata_i,
  input  logic [CW-1:0]            idx_i,
  output logic [7:0]               byte_o,
  output logic [CW-1:0]            total_o,
  output logic                     ok_o
);
  localparam int PIW = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1;

  logic [7:0]    hdr [HDR_BYTES];
  logic [7:0]    pay [MAX_PAYLOAD];
  logic [3:0]    n_m1, wr_nib, cmd_i2c, len_i2c;
  logic          len_ok;
  logic [CW-1:0] pidx;
  kind_e         kind;
  step_e         step;

  for (genvar k = 0; k < MAX_PAYLOAD; k++) begin : g_unpack
    assign pay[k] = wdata_i[8*k +: 8];
  end

  assign kind    = kind_e'(kind_i);
  assign step    = step_e'(mode_i);
  assign n_m1    = len_i[3:0] - 4'd1;
  assign wr_nib  = len_i[3:0] + 4'd4;   // wraps at 16 bytes
  assign len_ok  = (len_i != '0) && (int'(len_i) <= MAX_PAYLOAD);
  assign cmd_i2c = ((step != STEP_STOP) ? CMD_MOT : 4'h0) | {3'b000, addr_i[0]};
  assign pidx    = idx_i - CW'(HDR_BYTES);

  always_comb begin
    unique case (step)
      STEP_WRITE: len_i2c = 4'd5;
      STEP_READ:  len_i2c = 4'd4;
      default:    len_i2c = 4'd3;
    endcase
  end

  always_comb begin
    hdr[0]  = addr_i[7:0];
    hdr[1]  = addr_i[15:8];
    hdr[2]  = '0;
    hdr[3]  = '0;
    total_o = CW'(HDR_BYTES);
    ok_o    = 1'b0;
    unique case (kind)
      KIND_NWR: begin
        hdr[2]  = {CMD_NWR, 4'h0};
        hdr[3]  = {wr_nib, n_m1};
        total_o = CW'(HDR_BYTES) + CW'(len_i);
        ok_o    = len_ok;
      end
      KIND_NRD: begin
        hdr[2] = {CMD_NRD, 4'h0};
        hdr[3] = {4'd4, n_m1};
        ok_o   = len_ok;
      end
      KIND_I2C: begin
        hdr[0]  = addr_i[8:1];
        hdr[1]  = {1'b0, addr_i[15:9]};
        hdr[2]  = {cmd_i2c, 4'h0};
        hdr[3]  = {len_i2c, 4'h0};
        total_o = CW'(HDR_BYTES) + ((step == STEP_WRITE) ? CW'(1) : CW'(0));
        ok_o    = 1'b1;
      end
      default: ok_o = 1'b0;
    endcase
  end

  assign byte_o = (idx_i < CW'(HDR_BYTES)) ? hdr[idx_i[1:0]] : pay[pidx[PIW-1:0]];

  // R3/R4/R8: an accepted request always has a header and fits the payload space
  always_comb begin
    if (ok_o) begin
      assert_total_range_R3: assert (total_o >= CW'(HDR_BYTES) &&
                                     int'(total_o) <= HDR_BYTES + MAX_PAYLOAD);
    end
  end
endmodule

// File: rtl/aux_req_ser.sv
module aux_req_ser #(
  parameter int CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ok_i,
  input  logic [CW-1:0] total_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          last_o,
  output logic          err_o,
  output logic [CW-1:0] idx_o
);
  logic          busy_q, err_q;
  logic [CW-1:0] idx_q;

  assign valid_o = busy_q;
  assign last_o  = busy_q && (idx_q == total_i - CW'(1));
  assign err_o   = err_q;
  assign idx_o   = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (ok_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
          end else begin
            err_q <= 1'b1;
          end
        end
      end else if (ready_i) begin
        if (last_o) busy_q <= 1'b0;
        else        idx_q  <= idx_q + CW'(1);
      end
    end
  end

  assert_err_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> !err_q);
  assert_err_no_valid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> !busy_q);
  assert_last_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);
  assert_idx_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (idx_q < total_i));
  assert_stall_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !ready_i) |=> (busy_q && $stable(idx_q)));
  assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !(ready_i && last_o)) |=> busy_q);
endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt
  import aux_req_pkg::*;
#(
  parameter int AW          = 16,
  parameter int MAX_PAYLOAD = 16,
  parameter int LW          = $clog2(MAX_PAYLOAD + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [1:0]               kind_i,
  input  logic [1:0]               mode_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [LW-1:0]            len_i,
  input  logic [8*MAX_PAYLOAD-1:0] wdata_i,
  output logic [7:0]               tx_data_o,
  output logic                     tx_valid_o,
  input  logic                     tx_ready_i,
  output logic                     tx_last_o,
  output logic                     err_o
);
  localparam int CW = $clog2(MAX_PAYLOAD + HDR_BYTES + 1);

  logic [CW-1:0] idx, total;
  logic          ok;

  aux_req_hdr #(
    .AW(AW), .MAX_PAYLOAD(MAX_PAYLOAD), .LW(LW), .CW(CW)
  ) u_hdr (
    .kind_i  (kind_i),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .len_i   (len_i),
    .wdata_i (wdata_i),
    .idx_i   (idx),
    .byte_o  (tx_data_o),
    .total_o (total),
    .ok_o    (ok)
  );

  aux_req_ser #(.CW(CW)) u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ok_i    (ok),
    .total_i (total),
    .ready_i (tx_ready_i),
    .valid_o (tx_valid_o),
    .last_o  (tx_last_o),
    .err_o   (err_o),
    .idx_o   (idx)
  );

  // R10: stream byte holds under backpressure (inputs are held by contract)
  assert_data_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));
  assert_last_needs_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
endmodule

// File: tb/aux_req_fmt_bench.sv
`timescale 1ns/1ps
module aux_req_fmt_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   kind = 2'b00;
  logic [1:0]   mode = 2'b00;
  logic [15:0]  addr = '0;
  logic [4:0]   len = '0;
  logic [127:0] wdata = '0;
  logic [7:0]   tx_data;
  logic         tx_valid, tx_last, err;
  logic         tx_ready = 1'b1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] exp_b [20];
  string      exp_t [20];
  int         exp_n;

  always #10 clk = ~clk;

  aux_req_fmt u_aux_req_fmt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind), .mode_i(mode),
    .addr_i(addr), .len_i(len), .wdata_i(wdata), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_last_o(tx_last), .err_o(err)
  );

  task automatic check_eq(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic build_expected();
    logic [3:0] cmd, ln;
    if (kind == 2'b10) begin
      cmd = ((mode != 2'b11) ? 4'h4 : 4'h0) | {3'b000, addr[0]};
      ln  = (mode == 2'b01) ? 4'd5 : (mode == 2'b10) ? 4'd4 : 4'd3;
      exp_b[0] = addr[8:1];           exp_t[0] = "R7";
      exp_b[1] = {1'b0, addr[15:9]};  exp_t[1] = "R7";
      exp_b[2] = {cmd, 4'h0};         exp_t[2] = "R6";
      exp_b[3] = {ln, 4'h0};          exp_t[3] = "R8";
      exp_n = 4;
      if (mode == 2'b01) begin
        exp_b[4] = wdata[7:0]; exp_t[4] = "R8"; exp_n = 5;
      end
    end else begin
      exp_b[0] = addr[7:0];  exp_t[0] = "R2";
      exp_b[1] = addr[15:8]; exp_t[1] = "R2";
      if (kind == 2'b00) begin
        exp_b[2] = 8'h80; exp_t[2] = "R3";
        exp_b[3] = {4'(int'(len) + 4), 4'(int'(len) - 1)}; exp_t[3] = "R3";
        for (int k = 0; k < int'(len); k++) begin
          exp_b[4+k] = wdata[8*k +: 8]; exp_t[4+k] = "R3";
        end
        exp_n = 4 + int'(len);
      end else begin
        exp_b[2] = 8'h90; exp_t[2] = "R4";
        exp_b[3] = {4'h4, 4'(int'(len) - 1)}; exp_t[3] = "R4";
        exp_n = 4;
      end
    end
  endtask

  task automatic run_req(bit stall, bit poke);
    int got = 0, cyc = 0;
    bit hold = 1'b0;
    logic [7:0] held = '0;
    build_expected();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_eq("R12", "valid after start", int'(tx_valid), 1);
    while (got < exp_n && cyc < 200) begin
      tx_ready = stall ? (cyc % 3 != 1) : 1'b1;
      start    = (poke && cyc == 1);
      if (hold) check_eq("R10", "byte held under stall", int'(tx_data), int'(held));
      if (!tx_valid) begin
        check_eq("R12", "valid dropped mid request", 0, 1);
        break;
      end
      if (tx_ready) begin
        check_eq(exp_t[got], $sformatf("byte %0d", got), int'(tx_data), int'(exp_b[got]));
        check_eq("R9", $sformatf("last at byte %0d", got), int'(tx_last), int'(got == exp_n - 1));
        got++;
        hold = 1'b0;
      end else begin
        hold = 1'b1;
        held = tx_data;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    tx_ready = 1'b1;
    check_eq("R12", "byte count", got, exp_n);
    check_eq("R11", "idle after last", int'(tx_valid), 0);
  endtask

  task automatic run_reject(string what);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check_eq("R5", {what, " err high"}, int'(err), 1);
    check_eq("R5", {what, " no valid"}, int'(tx_valid), 0);
    @(negedge clk);
    check_eq("R5", {what, " err pulse ends"}, int'(err), 0);
    check_eq("R5", {what, " still no valid"}, int'(tx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1", "valid in reset", int'(tx_valid), 0);
    check_eq("R1", "err in reset", int'(err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "valid after reset", int'(tx_valid), 0);
    check_eq("R1", "last after reset", int'(tx_last), 0);
    check_eq("R1", "err after reset", int'(err), 0);

    // R3: native writes, every count
    for (int n = 1; n <= 16; n++) begin
      kind = 2'b00; len = 5'(n); addr = 16'(16'h1234 + n * 37);
      for (int k = 0; k < 16; k++) wdata[8*k +: 8] = 8'(n * 17 + k * 29 + 3);
      run_req(n % 2 == 1, n == 5);
    end
    // R4: native reads, every count
    for (int n = 1; n <= 16; n++) begin
      kind = 2'b01; len = 5'(n); addr = 16'(16'hA5C3 ^ (n * 257));
      run_req(n % 3 == 0, n == 7);
    end
    // R6, R7, R8: all I2C steps, both address LSB values
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        kind = 2'b10; mode = 2'(m); len = 5'd0;
        addr = (m == 3) ? 16'hB3C4 | 16'(b) : 16'h00A0 | 16'(b);
        wdata[7:0] = 8'(8'h5A + m * 16 + b);
        run_req(b == 1, m == 1);
      end
    end
    // R5: refused requests
    kind = 2'b00; len = 5'd0;  run_reject("write N=0");
    kind = 2'b00; len = 5'd17; run_reject("write N=17");
    kind = 2'b00; len = 5'd31; run_reject("write N=31");
    kind = 2'b01; len = 5'd0;  run_reject("read N=0");
    kind = 2'b01; len = 5'd17; run_reject("read N=17");
    kind = 2'b11; len = 5'd4;  run_reject("reserved kind");
    // request after refusal still works
    kind = 2'b01; len = 5'd2; addr = 16'h0202;
    run_req(1'b0, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule